// File: doc/BRIEF.md
# Tagless Skewed Two-Way Branch Target Buffer

This block supplies branch targets to a fetch address generator whose table reads begin several blocks before the address they serve is known. Each entry holds a target address and the predecoded information of the block that follows the target. There are no tags: entries sit in two ways indexed by different hashes, each hash mixing the block address with a different half of the in-flight path bits. A one-bit-per-entry way predictor, indexed by the way-0 hash, selects the way whose contents are returned. No tag compare takes place.

A lookup presents a block address and path bits and receives, two clock edges later, the predicted way and a run of `RUN` contiguous entries from that way. The run gives one candidate target per branch when a fetch block may skip over not-taken branches. The read side is fully pipelined and accepts one lookup per cycle. An update port either allocates a missing target or corrects the way predictor after a way misprediction.

Top module: `skew_btb`

## Requirements
- R1: During and after reset `rd_valid` is low. Every entry holds target 0 and decode 0, and every way-predictor bit is 0 (way 0).
- R2: A lookup taken with `lk_valid` high at a rising edge produces `rd_valid` high with its result after the second rising edge. A cycle without a lookup produces `rd_valid` low two edges later.
- R3: Way-0 index: h0 = A[5:0] ^ F ^ {P[1:0],4'b0}, where F = A[11:6] ^ {2'b0,A[15:12]} for the default widths. In general F is the XOR of every IDX_W-bit chunk of the address above the lowest one.
- R4: Way-1 index: h1 = A[5:0] ^ rotate_right_1(F) ^ {P[3:2],4'b0}. Way 1 uses the upper half of the path bits and way 0 the lower half.
- R5: The way-predictor bit at index h0 is output on `rd_way` (0 = way 0, 1 = way 1). All returned entries come from that way only, with base index h0 for way 0 and h1 for way 1.
- R6: Slot k of the returned run is the entry at (base + k) mod 2^IDX_W of the selected way. Its target sits at `rd_tgt[k*TGT_W +: TGT_W]` and its decode at `rd_dec[k*DEC_W +: DEC_W]`.
- R7: An update with `upd_alloc`=1 writes `{upd_tgt, upd_dec}` into the way opposite the current predictor bit at h0. The write goes to (that way's base + `upd_slot`) mod 2^IDX_W. The predictor bit is then set to the written way.
- R8: An update with `upd_alloc`=0 sets the predictor bit at h0 to `upd_way` and writes no entry.
- R9: Lookups on consecutive cycles are all accepted and each returns its own result on consecutive cycles, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Block address for the lookup |
| lk_path | input | PATH_W | In-flight path bits for the lookup |
| rd_valid | output | 1 | Lookup result valid |
| rd_way | output | 1 | Predicted way of the result |
| rd_tgt | output | RUN*TGT_W | Targets of the run, slot 0 in the low bits |
| rd_dec | output | RUN*DEC_W | Decode information of the run, slot 0 in the low bits |
| upd_valid | input | 1 | Update request |
| upd_alloc | input | 1 | 1 = allocate entry, 0 = way-predictor correction |
| upd_way | input | 1 | Correct way for a correction |
| upd_addr | input | ADDR_W | Block address of the update |
| upd_path | input | PATH_W | Path bits of the update |
| upd_slot | input | SLOT_W | Run slot written by an allocation |
| upd_tgt | input | TGT_W | Target to store |
| upd_dec | input | DEC_W | Decode information to store |

## Verification
The bench fills both ways of every index, so the two ways always hold different data. It then sweeps hundreds of address and path pairs back to back against an arithmetic model. A swapped or shared path half in the hashes, or a missing high-address fold, returns the wrong entry. A predictor read at the way-1 index returns the wrong way. An allocation at the last index with slot 1 must wrap to index 0: an unwrapped or misdirected run slot shows up as a stale target in slot 1. Allocations must go to the unpredicted way, and corrections must leave the data untouched; a design that overwrites the predicted way, or writes on a correction, loses a target the model still expects.

// File: rtl/skew_btb.sv
module skew_btb #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  parameter int PATH_W = 4,
  parameter int TGT_W  = 16,
  parameter int DEC_W  = 8,
  parameter int RUN    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [ADDR_W-1:0]      lk_addr,
  input  logic [PATH_W-1:0]      lk_path,
  output logic                   rd_valid,
  output logic                   rd_way,
  output logic [RUN*TGT_W-1:0]   rd_tgt,
  output logic [RUN*DEC_W-1:0]   rd_dec,
  input  logic                   upd_valid,
  input  logic                   upd_alloc,
  input  logic                   upd_way,
  input  logic [ADDR_W-1:0]      upd_addr,
  input  logic [PATH_W-1:0]      upd_path,
  input  logic [((RUN>1)?$clog2(RUN):1)-1:0] upd_slot,
  input  logic [TGT_W-1:0]       upd_tgt,
  input  logic [DEC_W-1:0]       upd_dec
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int SLOT_W = (RUN > 1) ? $clog2(RUN) : 1;
  localparam int PH     = PATH_W / 2;
  localparam int ENT_W  = TGT_W + DEC_W;

  function automatic logic [IDX_W-1:0] fold_hi(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] f;
    f = '0;
    for (int c = 1; c * IDX_W < ADDR_W; c++)
      f = f ^ IDX_W'(a >> (c * IDX_W));
    return f;
  endfunction

  function automatic logic [IDX_W-1:0] hash0(input logic [ADDR_W-1:0] a,
                                             input logic [PATH_W-1:0] p);
    logic [IDX_W-1:0] pb;
    pb = IDX_W'(p[PH-1:0]) << (IDX_W - PH);
    return a[IDX_W-1:0] ^ fold_hi(a) ^ pb;
  endfunction

  function automatic logic [IDX_W-1:0] hash1(input logic [ADDR_W-1:0] a,
                                             input logic [PATH_W-1:0] p);
    logic [IDX_W-1:0] f, pb;
    f  = fold_hi(a);
    pb = IDX_W'(p[PATH_W-1:PH]) << (IDX_W - PH);
    return a[IDX_W-1:0] ^ {f[0], f[IDX_W-1:1]} ^ pb;
  endfunction

  logic [ENT_W-1:0] way0_q [DEPTH];
  logic [ENT_W-1:0] way1_q [DEPTH];
  logic [DEPTH-1:0] wp_q;

  logic             s1_v;
  logic [IDX_W-1:0] s1_i0, s1_i1;
  logic             s2_v, s2_way;
  logic [ENT_W-1:0] s2_ent [RUN];

  logic             sel;
  logic [IDX_W-1:0] base;
  assign sel  = wp_q[s1_i0];
  assign base = sel ? s1_i1 : s1_i0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_i0  <= '0;
      s1_i1  <= '0;
      s2_v   <= 1'b0;
      s2_way <= 1'b0;
    end else begin
      s1_v   <= lk_valid;
      s1_i0  <= hash0(lk_addr, lk_path);
      s1_i1  <= hash1(lk_addr, lk_path);
      s2_v   <= s1_v;
      s2_way <= sel;
    end
  end

  for (genvar k = 0; k < RUN; k++) begin : g_slot
    logic [IDX_W-1:0] idx;
    assign idx = base + IDX_W'(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s2_ent[k] <= '0;
      else        s2_ent[k] <= sel ? way1_q[idx] : way0_q[idx];
    end
    assign rd_tgt[k*TGT_W +: TGT_W] = s2_ent[k][ENT_W-1:DEC_W];
    assign rd_dec[k*DEC_W +: DEC_W] = s2_ent[k][DEC_W-1:0];
  end

  assign rd_valid = s2_v;
  assign rd_way   = s2_way;

  logic [IDX_W-1:0] u_i0, u_i1, u_idx;
  logic             u_way;
  assign u_i0  = hash0(upd_addr, upd_path);
  assign u_i1  = hash1(upd_addr, upd_path);
  assign u_way = upd_alloc ? ~wp_q[u_i0] : upd_way;
  assign u_idx = (u_way ? u_i1 : u_i0) + IDX_W'(upd_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        way0_q[i] <= '0;
        way1_q[i] <= '0;
      end
    end else if (upd_valid) begin
      wp_q[u_i0] <= u_way;
      if (upd_alloc) begin
        if (u_way) way1_q[u_idx] <= {upd_tgt, upd_dec};
        else       way0_q[u_idx] <= {upd_tgt, upd_dec};
      end
    end
  end
endmodule

// File: rtl/skew_btb_chk.sv
module skew_btb_chk #(
  parameter int IDX_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lk_valid,
  input logic                  rd_valid,
  input logic                  rd_way,
  input logic                  upd_valid,
  input logic                  upd_alloc,
  input logic                  upd_way,
  input logic [IDX_W-1:0]      upd_i0,
  input logic [(1<<IDX_W)-1:0] wp
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##2 rd_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> ##2 !rd_valid);

  a_r7_alloc_flips_way: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_alloc) |=> wp[$past(upd_i0)] != $past(wp[upd_i0]));

  a_r8_fix_sets_way: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_alloc) |=> wp[$past(upd_i0)] == $past(upd_way));

  a_r5_way_known: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$isunknown(rd_way));
endmodule

bind skew_btb skew_btb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rd_valid(rd_valid),
  .rd_way(rd_way), .upd_valid(upd_valid), .upd_alloc(upd_alloc),
  .upd_way(upd_way), .upd_i0(u_i0), .wp(wp_q)
);

// File: tb/sim_skew_btb.sv
module sim_skew_btb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lk_valid = 1'b0;
  logic [15:0] lk_addr = '0;
  logic [3:0]  lk_path = '0;
  logic        rd_valid, rd_way;
  logic [31:0] rd_tgt;
  logic [15:0] rd_dec;
  logic        upd_valid = 1'b0, upd_alloc = 1'b0, upd_way = 1'b0;
  logic [15:0] upd_addr = '0;
  logic [3:0]  upd_path = '0;
  logic [0:0]  upd_slot = '0;
  logic [15:0] upd_tgt = '0;
  logic [7:0]  upd_dec = '0;

  skew_btb u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_path(lk_path), .rd_valid(rd_valid), .rd_way(rd_way), .rd_tgt(rd_tgt),
    .rd_dec(rd_dec), .upd_valid(upd_valid), .upd_alloc(upd_alloc),
    .upd_way(upd_way), .upd_addr(upd_addr), .upd_path(upd_path),
    .upd_slot(upd_slot), .upd_tgt(upd_tgt), .upd_dec(upd_dec)
  );

  int n_cmp = 0, n_bad = 0;
  logic [23:0] m0 [64];
  logic [23:0] m1 [64];
  logic [63:0] mwp;
  logic [15:0] q_addr [512];
  logic [3:0]  q_path [512];
  int nq;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] fhi(input logic [15:0] a);
    return a[11:6] ^ {2'b00, a[15:12]};
  endfunction
  function automatic logic [5:0] bh0(input logic [15:0] a, input logic [3:0] p);
    return a[5:0] ^ fhi(a) ^ {p[1:0], 4'b0000};
  endfunction
  function automatic logic [5:0] bh1(input logic [15:0] a, input logic [3:0] p);
    logic [5:0] f;
    f = fhi(a);
    return a[5:0] ^ {f[0], f[5:1]} ^ {p[3:2], 4'b0000};
  endfunction

  task automatic do_upd(input logic alloc, input logic way, input logic [15:0] a,
                        input logic [3:0] p, input logic slot,
                        input logic [15:0] t, input logic [7:0] d);
    logic [5:0] i0, ix;
    logic w;
    @(negedge clk);
    upd_valid = 1'b1; upd_alloc = alloc; upd_way = way; upd_addr = a;
    upd_path = p; upd_slot = slot; upd_tgt = t; upd_dec = d;
    i0 = bh0(a, p);
    w  = alloc ? ~mwp[i0] : way;
    ix = (w ? bh1(a, p) : i0) + 6'(slot);
    if (alloc) begin
      if (w) m1[ix] = {t, d};
      else   m0[ix] = {t, d};
    end
    mwp[i0] = w;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic sweep();
    for (int n = 0; n < nq + 2; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        logic [5:0] i0, b;
        logic w;
        logic [23:0] e;
        i0 = bh0(q_addr[n-2], q_path[n-2]);
        w  = mwp[i0];
        b  = w ? bh1(q_addr[n-2], q_path[n-2]) : i0;
        chk("R2/R9 valid", 32'(rd_valid), 32'd1);
        chk("R5 way", 32'(rd_way), 32'(w));
        for (int k = 0; k < 2; k++) begin
          e = w ? m1[6'(b + 6'(k))] : m0[6'(b + 6'(k))];
          chk(k == 0 ? "R3/R4/R7 slot0" : "R6 slot1",
              {rd_tgt[k*16 +: 16], rd_dec[k*8 +: 8]}, 32'(e));
        end
      end
      if (n < nq) begin
        lk_valid = 1'b1; lk_addr = q_addr[n]; lk_path = q_path[n];
      end else lk_valid = 1'b0;
    end
    @(negedge clk);
    chk("R2 idle", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m0[i] = '0; m1[i] = '0; end
    mwp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;

    // R1: empty table reads zero through way 0
    for (int i = 0; i < 16; i++) begin
      q_addr[i] = 16'(i * 16'h0457); q_path[i] = 4'(i);
    end
    nq = 16;
    sweep();

    // R7: fill both ways with distinct data
    for (int i = 0; i < 64; i++) begin
      do_upd(1'b1, 1'b0, 16'(i), 4'd0, 1'b0, 16'hA000 + 16'(i), 8'(i));
      do_upd(1'b1, 1'b0, 16'(i), 4'd0, 1'b0, 16'h5000 + 16'(i), 8'h80 | 8'(i));
    end
    // R8: correction on even indices
    for (int i = 0; i < 64; i += 2)
      do_upd(1'b0, 1'b1, 16'(i), 4'd0, 1'b0, 16'hDEAD, 8'hEE);

    // R8 targeted: index 2 now reads way 1, data unchanged
    q_addr[0] = 16'd2; q_path[0] = 4'd0; nq = 1;
    sweep();
    chk("R8 way", 32'(rd_way), 32'd1);

    // R3/R4/R5/R9 broad back-to-back sweep
    for (int i = 0; i < 256; i++) begin
      q_addr[i] = 16'(i * 16'h0139); q_path[i] = 4'(i >> 4) ^ 4'(i);
    end
    nq = 256;
    sweep();

    // R6/R7: slot-1 allocation at the last index wraps to index 0
    do_upd(1'b1, 1'b0, 16'd63, 4'd0, 1'b1, 16'hBEEF, 8'h5A);
    q_addr[0] = 16'd63; q_path[0] = 4'd0; nq = 1;
    sweep();
    chk("R6 wrap tgt", 32'(rd_tgt[31:16]), 32'hBEEF);
    chk("R7 alloc way", 32'(rd_way), 32'd1);

    // R7 with path bits and high address bits
    do_upd(1'b1, 1'b0, 16'hF3C5, 4'hD, 1'b0, 16'h1234, 8'h77);
    do_upd(1'b1, 1'b0, 16'h8A11, 4'h6, 1'b1, 16'h4321, 8'h33);
    for (int i = 0; i < 256; i++) begin
      q_addr[i] = 16'(i * 16'h2E1B) ^ 16'hF3C5; q_path[i] = 4'(i * 7);
    end
    q_addr[0] = 16'hF3C5; q_path[0] = 4'hD;
    q_addr[1] = 16'h8A11; q_path[1] = 4'h6;
    nq = 256;
    sweep();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule